// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit-style microcontroller core. It gathers thirteen request groups: one auxiliary group that merges eight individually enabled on-chip sources onto a single vector, six external pins, three timer overflows, two serial ports and a watchdog. For each group it keeps a pending flag and gates that flag with the group enable. The non-auxiliary groups are also gated by a global enable. The block then picks one winner and presents its vector address to the core with a request strobe.

The winner is chosen from two programmable priority levels, and the natural group order breaks ties inside a level. The auxiliary group sits above everything and always counts as the high level. When the core acknowledges a vector, the block clears the flags that are defined to clear themselves. It also records the level now in service, so that only a high-level request can interrupt a low-level handler. A return-from-interrupt pulse releases the most recently entered level. Enable and priority bits arrive as plain register inputs. Register decoding and the peripherals themselves are outside the block.

Top module: `irq_arbiter`

## Requirements
- R1: After synchronous reset, `irq_req` is 0, `irq_vec` is 0x00 and no level is in service.
- R2: Group indices and vectors, in natural order, are: 0 auxiliary 0x33, 1 external 0 0x03, 2 timer 0 0x0B, 3 external 1 0x13, 4 timer 1 0x1B, 5 serial 0 0x23, 6 timer 2 0x2B, 7 serial 1 0x3B, 8-11 externals 2-5 at 0x43/0x4B/0x53/0x5B, 12 watchdog 0x63. Bit k of `grp_en`, `grp_hi` and `flag_clr` belongs to group k+1.
- R3: The auxiliary flag is set while any bit of `aux_src & aux_en` is 1. It requests vector 0x33 only when `aux_grp_en` is 1. It does not depend on `glob_en`.
- R4: A non-auxiliary group requests only when its `grp_en` bit and `glob_en` are both 1. A flag latched while the group was disabled is served once it is enabled.
- R5: A group whose `grp_hi` bit is 1 is at the high level, and the auxiliary group is always high. A high request wins over a low one, and inside a level the lower group index wins.
- R6: Once `irq_req` rises, it and `irq_vec` hold unchanged until a cycle with `irq_ack`=1. `irq_req` is 0 in the cycle after that acknowledge.
- R7: External 0/1 in edge mode (`ext_edge` bit 0/1 = 1) set their flag on a rising edge of `ext_in[0]`/`ext_in[1]`. That flag, like the timer 0/1 overflow flags, is cleared when its vector is acknowledged. A pin held high does not request again.
- R8: External 0/1 in level mode (`ext_edge` bit = 0) have a flag that follows the pin, and an acknowledge does not clear it.
- R9: A serial group requests when it receives a receive pulse or a transmit pulse. The serial, timer 2, external 2-5 (rising edge) and watchdog flags stay set after an acknowledge.
- R10: While a high level is in service, no request is raised. While only a low level is in service, only high-level requests are raised.
- R11: `irq_reti` releases the high level if it is in service, otherwise the low level.
- R12: A `flag_clr` bit clears that group's latched flag. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_src | input | 8 | Auxiliary source requests (bit 0 supply/breakpoint, 1 analog supply, 2 SPI rx, 3 SPI tx, 4 ms timer, 5 ADC, 6 summation, 7 seconds timer) |
| aux_en | input | 8 | Per-source auxiliary enables |
| aux_grp_en | input | 1 | Auxiliary group enable |
| glob_en | input | 1 | Global enable for non-auxiliary groups |
| grp_en | input | 12 | Enables of groups 1 to 12 |
| grp_hi | input | 12 | High-level select of groups 1 to 12 |
| ext_in | input | 6 | External interrupt pins 0 to 5, active high |
| ext_edge | input | 2 | Edge mode for external 0 and 1 |
| tmr_ovf | input | 3 | Timer 0 to 2 overflow pulses |
| ser_rx | input | 2 | Serial 0/1 receive pulses |
| ser_tx | input | 2 | Serial 0/1 transmit pulses |
| wdog_evt | input | 1 | Watchdog event pulse |
| flag_clr | input | 12 | Software flag clear for groups 1 to 12 |
| irq_ack | input | 1 | Core acknowledges the presented vector |
| irq_reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | 8 | Vector address |

## Verification
The hardest state to reach is two nested handlers: a low-level handler in service with a high-level handler stacked on top, while a further low request waits. The bench builds this in steps. It acknowledges a timer 2 request, raises a low watchdog event that must stay silent, and then raises a high-level external 3 request that must get through. The two return pulses that follow show that the first one leaves the watchdog blocked and the second one releases it. Other tests check the relative priority of groups by latching several flags while the global enable is off and then enabling them all in the same cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NGRP     = 13;
  localparam int IDX_W    = $clog2(NGRP);
  localparam int VEC_W    = 8;
  localparam int NUM_AUX  = 8;
  localparam int NUM_EXT  = 6;
  localparam int NUM_TMR  = 3;
  localparam int NUM_SER  = 2;
  localparam int VEC_STEP = 8;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'h03;
  localparam logic [VEC_W-1:0] AUX_VEC  = 8'h33;

  localparam int G_AUX  = 0;
  localparam int G_EXT0 = 1;
  localparam int G_TMR0 = 2;
  localparam int G_EXT1 = 3;
  localparam int G_TMR1 = 4;
  localparam int G_SER0 = 5;
  localparam int G_TMR2 = 6;
  localparam int G_SER1 = 7;
  localparam int G_EXT2 = 8;
  localparam int G_WDOG = 12;

  // groups whose flag clears when their vector is acknowledged
  localparam logic [NGRP-1:0] AUTO_CLR =
    NGRP'((1 << G_EXT0) | (1 << G_TMR0) | (1 << G_EXT1) | (1 << G_TMR1));

  // vectors after timer 2 skip the slot taken by the auxiliary vector
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] g);
    if (g == IDX_W'(G_AUX))
      return AUX_VEC;
    else if (int'(g) <= G_TMR2)
      return VEC_BASE + VEC_W'(VEC_STEP * (int'(g) - 1));
    else
      return VEC_BASE + VEC_W'(VEC_STEP * int'(g));
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_AUX-1:0] aux_src,
  input  logic [NUM_AUX-1:0] aux_en,
  input  logic [NUM_EXT-1:0] ext_in,
  input  logic [1:0]         ext_edge,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic [NUM_SER-1:0] ser_rx,
  input  logic [NUM_SER-1:0] ser_tx,
  input  logic               wdog_evt,
  input  logic [NGRP-2:0]    sw_clr,
  input  logic [NGRP-1:0]    ack_clr,
  output logic [NGRP-1:0]    flags
);
  localparam int NUM_HI_EXT = NUM_EXT - 2;

  logic [NUM_EXT-1:0] ext_q;
  logic [NUM_EXT-1:0] rise;
  logic [NGRP-1:0]    set_v, clr_v, flags_nxt;

  assign rise  = ext_in & ~ext_q;
  assign clr_v = {sw_clr, 1'b0} | (ack_clr & AUTO_CLR);

  always_comb begin
    set_v         = '0;
    set_v[G_EXT0] = rise[0];
    set_v[G_TMR0] = tmr_ovf[0];
    set_v[G_EXT1] = rise[1];
    set_v[G_TMR1] = tmr_ovf[1];
    set_v[G_SER0] = ser_rx[0] | ser_tx[0];
    set_v[G_TMR2] = tmr_ovf[2];
    set_v[G_SER1] = ser_rx[1] | ser_tx[1];
    for (int k = 0; k < NUM_HI_EXT; k++)
      set_v[G_EXT2 + k] = rise[2 + k];
    set_v[G_WDOG] = wdog_evt;
  end

  always_comb begin
    flags_nxt        = set_v | (flags & ~clr_v);
    flags_nxt[G_AUX] = |(aux_src & aux_en);
    if (!ext_edge[0]) flags_nxt[G_EXT0] = ext_in[0];
    if (!ext_edge[1]) flags_nxt[G_EXT1] = ext_in[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
      flags <= '0;
    end else begin
      ext_q <= ext_in;
      flags <= flags_nxt;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
(
  input  logic [NGRP-1:0]  req,
  input  logic [NGRP-1:0]  hi,
  input  logic             ins_hi,
  input  logic             ins_lo,
  output logic             win_v,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_hi
);
  logic [NGRP-1:0] elig_hi, elig_lo;

  assign elig_hi = ins_hi            ? '0 : (req & hi);
  assign elig_lo = (ins_hi | ins_lo) ? '0 : (req & ~hi);

  // scan downwards so the lowest index is written last; high overrides low
  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    win_hi  = 1'b0;
    for (int g = NGRP - 1; g >= 0; g--)
      if (elig_lo[g]) begin
        win_v   = 1'b1;
        win_idx = IDX_W'(g);
      end
    for (int g = NGRP - 1; g >= 0; g--)
      if (elig_hi[g]) begin
        win_v   = 1'b1;
        win_idx = IDX_W'(g);
        win_hi  = 1'b1;
      end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic enter_hi,
  input  logic leave,
  output logic ins_hi,
  output logic ins_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else if (enter) begin
      if (enter_hi) ins_hi <= 1'b1;
      else          ins_lo <= 1'b1;
    end else if (leave) begin
      if (ins_hi) ins_hi <= 1'b0;
      else        ins_lo <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_AUX-1:0] aux_src,
  input  logic [NUM_AUX-1:0] aux_en,
  input  logic               aux_grp_en,
  input  logic               glob_en,
  input  logic [NGRP-2:0]    grp_en,
  input  logic [NGRP-2:0]    grp_hi,
  input  logic [NUM_EXT-1:0] ext_in,
  input  logic [1:0]         ext_edge,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic [NUM_SER-1:0] ser_rx,
  input  logic [NUM_SER-1:0] ser_tx,
  input  logic               wdog_evt,
  input  logic [NGRP-2:0]    flag_clr,
  input  logic               irq_ack,
  input  logic               irq_reti,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  logic [NGRP-1:0]  flags, req_v, en_full, hi_full, ack_clr;
  logic             ins_hi, ins_lo;
  logic             win_v, win_hi;
  logic [IDX_W-1:0] win_idx, sel_idx;
  logic             sel_hi;
  logic             taken;

  assign taken   = irq_req & irq_ack;
  assign en_full = {grp_en & {(NGRP-1){glob_en}}, aux_grp_en};
  assign hi_full = {grp_hi, 1'b1};
  assign req_v   = flags & en_full;
  assign ack_clr = taken ? (NGRP'(1) << sel_idx) : '0;

  irq_flag_bank u_flags (
    .clk(clk), .rst(rst), .aux_src(aux_src), .aux_en(aux_en),
    .ext_in(ext_in), .ext_edge(ext_edge), .tmr_ovf(tmr_ovf),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .wdog_evt(wdog_evt),
    .sw_clr(flag_clr), .ack_clr(ack_clr), .flags(flags)
  );

  irq_pick u_pick (
    .req(req_v), .hi(hi_full), .ins_hi(ins_hi), .ins_lo(ins_lo),
    .win_v(win_v), .win_idx(win_idx), .win_hi(win_hi)
  );

  irq_inservice u_ins (
    .clk(clk), .rst(rst), .enter(taken), .enter_hi(sel_hi),
    .leave(irq_reti), .ins_hi(ins_hi), .ins_lo(ins_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      sel_idx <= '0;
      sel_hi  <= 1'b0;
    end else if (taken) begin
      irq_req <= 1'b0;
    end else if (!irq_req && !irq_ack && win_v) begin
      irq_req <= 1'b1;
      irq_vec <= vec_of(win_idx);
      sel_idx <= win_idx;
      sel_hi  <= win_hi;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               irq_ack,
  input logic               irq_reti,
  input logic               glob_en,
  input logic [NUM_TMR-1:0] tmr_ovf,
  input logic               ins_hi,
  input logic               ins_lo,
  input logic               sel_hi,
  input logic [NGRP-1:0]    flags
);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));
  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack |=> !irq_req);
  a_r10_hi_blocks: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(ins_hi));
  a_r10_lo_nest: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && $past(ins_lo) |-> sel_hi);
  a_r3_aux_only: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && !$past(glob_en) |-> irq_vec == AUX_VEC);
  a_r7_tmr0_clr: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack && irq_vec == 8'h0B && !tmr_ovf[0] |=> !flags[G_TMR0]);
  a_r11_hi_first: assert property (@(posedge clk) disable iff (rst)
    irq_reti && !irq_ack && ins_hi |=> !ins_hi && ($past(ins_lo) == ins_lo));
  a_r11_lo_next: assert property (@(posedge clk) disable iff (rst)
    irq_reti && !irq_ack && !ins_hi |=> !ins_lo);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .irq_reti(irq_reti), .glob_en(glob_en),
  .tmr_ovf(tmr_ovf), .ins_hi(ins_hi), .ins_lo(ins_lo),
  .sel_hi(sel_hi), .flags(flags)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  aux_src, aux_en;
  logic        aux_grp_en, glob_en;
  logic [11:0] grp_en, grp_hi, flag_clr;
  logic [5:0]  ext_in;
  logic [1:0]  ext_edge;
  logic [2:0]  tmr_ovf;
  logic [1:0]  ser_rx, ser_tx;
  logic        wdog_evt, irq_ack, irq_reti;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_arbiter uut (.*);

  function automatic logic [7:0] exp_vec(input int g);
    logic [7:0] t [13] = '{8'h33, 8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h2B,
                           8'h3B, 8'h43, 8'h4B, 8'h53, 8'h5B, 8'h63};
    return t[g];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_vec(input string tag, input logic [7:0] v);
    int k = 0;
    while (!irq_req && k < 20) begin
      @(negedge clk);
      k++;
    end
    check({tag, " req"}, 32'(irq_req), 32'd1);
    check({tag, " vec"}, 32'(irq_vec), 32'(v));
  endtask

  task automatic expect_idle(input string tag, input int n);
    logic seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      seen |= irq_req;
    end
    check({tag, " idle"}, 32'(seen), 32'd0);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    check("R6 req drops after ack", 32'(irq_req), 32'd0);
    tick(1);
  endtask

  task automatic do_reti();
    irq_reti = 1'b1; tick(1); irq_reti = 1'b0;
  endtask

  task automatic sw_clear(input logic [11:0] m);
    flag_clr = m; tick(1); flag_clr = '0;
  endtask

  task automatic fire(input int g);
    case (g)
      1: ext_in[0] = 1'b1;   2: tmr_ovf[0] = 1'b1;
      3: ext_in[1] = 1'b1;   4: tmr_ovf[1] = 1'b1;
      5: ser_rx[0] = 1'b1;   6: tmr_ovf[2] = 1'b1;
      7: ser_tx[1] = 1'b1;   12: wdog_evt = 1'b1;
      default: ext_in[g - 6] = 1'b1;
    endcase
    tick(1);
    ext_in = '0; tmr_ovf = '0; ser_rx = '0; ser_tx = '0; wdog_evt = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req after reset", 32'(irq_req), 32'd0);
    check("R1 vec after reset", 32'(irq_vec), 32'd0);
    expect_idle("R1", 4);
  endtask

  task automatic t_aux();
    aux_en = 8'h04; aux_src = 8'h08; aux_grp_en = 1'b1;
    expect_idle("R3 unenabled aux source", 5);
    aux_src = 8'h04; aux_grp_en = 1'b0;
    expect_idle("R3 aux group disabled", 5);
    glob_en = 1'b0; aux_grp_en = 1'b1;
    expect_vec("R3 aux with glob_en=0", 8'h33);
    tick(3);
    check("R6 req held", 32'(irq_req), 32'd1);
    check("R6 vec held", 32'(irq_vec), 32'h33);
    do_ack();
    aux_src = '0;
    tick(2);
    do_reti();
    expect_idle("R3 aux source gone", 4);
    glob_en = 1'b1; aux_grp_en = 1'b0; aux_en = '0;
  endtask

  task automatic t_global();
    glob_en = 1'b0;
    fire(4);
    expect_idle("R4 glob_en=0", 5);
    glob_en = 1'b1;
    expect_vec("R4 latched flag served", 8'h1B);
    do_ack();
    do_reti();
    expect_idle("R7 timer 1 auto clear", 5);
    grp_en[5] = 1'b0;
    fire(6);
    expect_idle("R4 group enable off", 5);
    grp_en[5] = 1'b1;
    expect_vec("R4 group enable on", 8'h2B);
    do_ack(); sw_clear(12'h020); do_reti();
  endtask

  task automatic t_map();
    for (int g = 1; g < 13; g++) begin
      fire(g);
      expect_vec($sformatf("R2 group %0d", g), exp_vec(g));
      do_ack();
      sw_clear(12'(1) << (g - 1));
      do_reti();
      expect_idle("R12 after software clear", 3);
    end
  endtask

  task automatic t_order();
    glob_en = 1'b0;
    tmr_ovf[0] = 1'b1; ext_in[5] = 1'b1; wdog_evt = 1'b1;
    tick(1);
    tmr_ovf = '0; ext_in = '0; wdog_evt = 1'b0;
    tick(2);
    glob_en = 1'b1;
    expect_vec("R5 natural order first", 8'h0B);
    do_ack(); do_reti();
    expect_vec("R5 natural order second", 8'h5B);
    do_ack(); sw_clear(12'h400); do_reti();
    expect_vec("R5 natural order third", 8'h63);
    do_ack(); sw_clear(12'h800); do_reti();
    expect_idle("R5 order drained", 4);
  endtask

  task automatic t_level();
    glob_en = 1'b0;
    tmr_ovf[2] = 1'b1; ser_tx[1] = 1'b1;
    tick(1);
    tmr_ovf = '0; ser_tx = '0;
    grp_hi = 12'h040;
    glob_en = 1'b1;
    expect_vec("R5 high level wins", 8'h3B);
    do_ack();
    expect_idle("R10 high in service blocks", 5);
    sw_clear(12'h040);
    do_reti();
    expect_vec("R11 low served after reti", 8'h2B);
    do_ack(); sw_clear(12'h020); do_reti();
    grp_hi = '0;
  endtask

  task automatic t_nest();
    fire(6);
    expect_vec("R10 low handler", 8'h2B);
    do_ack();
    sw_clear(12'h020);
    fire(12);
    expect_idle("R10 low blocks low", 5);
    grp_hi = 12'h100;
    fire(9);
    expect_vec("R10 high preempts low", 8'h4B);
    do_ack();
    sw_clear(12'h100);
    do_reti();
    expect_idle("R11 low still in service", 5);
    do_reti();
    expect_vec("R11 both released", 8'h63);
    do_ack(); sw_clear(12'h800); do_reti();
    expect_idle("R11 drained", 4);
    grp_hi = '0;
  endtask

  task automatic t_ext();
    ext_in[0] = 1'b1;
    expect_vec("R7 edge external 0", 8'h03);
    do_ack(); do_reti();
    expect_idle("R7 held pin does not rerequest", 5);
    ext_in[0] = 1'b0;
    ext_edge = 2'b01;
    ext_in[1] = 1'b1;
    expect_vec("R8 level external 1", 8'h13);
    do_ack(); do_reti();
    expect_vec("R8 level flag survives ack", 8'h13);
    do_ack();
    ext_in[1] = 1'b0;
    tick(2);
    do_reti();
    expect_idle("R8 flag follows pin low", 5);
    ext_edge = 2'b11;
  endtask

  task automatic t_serial();
    fire(5);
    expect_vec("R9 serial 0 receive", 8'h23);
    do_ack(); do_reti();
    expect_vec("R9 serial flag persists", 8'h23);
    do_ack(); sw_clear(12'h010); do_reti();
    expect_idle("R12 serial cleared", 5);
    ser_tx[0] = 1'b1; tick(1); ser_tx[0] = 1'b0;
    expect_vec("R9 serial 0 transmit", 8'h23);
    do_ack(); sw_clear(12'h010); do_reti();
    flag_clr = 12'h020; tmr_ovf[2] = 1'b1;
    tick(1);
    flag_clr = '0; tmr_ovf = '0;
    expect_vec("R12 set wins over clear", 8'h2B);
    do_ack(); sw_clear(12'h020); do_reti();
    expect_idle("R12 end", 4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    aux_src = '0; aux_en = '0; aux_grp_en = 1'b0; glob_en = 1'b1;
    grp_en = '1; grp_hi = '0; flag_clr = '0; ext_in = '0; ext_edge = 2'b11;
    tmr_ovf = '0; ser_rx = '0; ser_tx = '0; wdog_evt = 1'b0;
    irq_ack = 1'b0; irq_reti = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_aux();
    t_global();
    t_map();
    t_order();
    t_level();
    t_nest();
    t_ext();
    t_serial();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule